// File: doc/BRIEF.md
# Handshaked Serial Byte Transfer Engine

This block sits on the host side of a byte link to a small system-controller microcontroller. Bytes move through an external shift unit that the peer clocks. This engine decides the direction of that unit, loads the outbound bytes, collects the inbound ones and keeps the peer in step over three wires. One wire is an input from the peer that asks for a transfer. The other two are outputs from the host: a per-byte acknowledge and a session (transfer active) signal.

Outbound packets enter a small queue and leave one at a time, byte by byte. The engine handles three kinds of inbound traffic: a reply to a request, an unsolicited packet, and a request that clashes with a peer transfer. Each finished inbound packet, and each finished request that expects no reply, appears as a one-cycle completion record. A build-time switch selects an older peer variant, in which both host outputs are active high and pin changes wait fixed hold times.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset, host_sess and host_ack are high (negated, default variant), pkt_valid is 0, req_ready is 1 and sr_dir_out is 0.
- R2: A request is refused with a one-cycle req_err pulse and never sent if its length is below 2 or above MAXLEN, or if byte 0 (bits 7:0 of req_data, the type) is above CMD_TYPE (default 1).
- R3: A queued packet starts only while idle with peer_want_n high. Starting drives sr_dir_out high, loads byte 0 onto sr_wdata with an sr_load pulse, and drives host_sess low.
- R4: If peer_want_n is low when the first byte's sr_done arrives, the engine backs off. It drives sr_dir_out low, pulses sr_rd, drives host_sess and host_ack high and returns to idle with the packet still queued, so it is sent again later.
- R5: Each later sr_done during sending loads the next byte (byte i at bits 8i+7:8i of req_data) and inverts host_ack.
- R6: The sr_done after the last byte drives sr_dir_out low and both host pins high. With req_reply=1 the engine waits for the reply. Otherwise it emits pkt_valid with pkt_reply=1 and pkt_len=0.
- R7: While idle or awaiting a reply, an sr_done is a discarded attention byte and drives host_sess low. Then each sr_done stores sr_rdata and inverts host_ack, until one arrives with peer_want_n high. That one ends the read and drives both pins high. The next sr_done emits the packet, with pkt_reply=1 for a reply and 0 for an unsolicited packet.
- R8: The receive buffer holds RXDEPTH (16) bytes. An sr_done that finds it full discards the byte and ends the read even while peer_want_n is low.
- R9: For a reply to a request of type BUS_TYPE (0), pkt_len is forced to 0 if the stored length is 2 or less, or if bit 1 of stored byte 1 is set. Otherwise the first two stored bytes are dropped. Replies to other types are delivered unchanged.
- R10: When a packet is emitted with peer_want_n low, host_sess is driven low at once and reading restarts without an attention byte. Otherwise the engine returns to idle and starts the next queued packet.
- R11: The queue holds QDEPTH (4) packets in order. req_ready is low while it is full, and a request offered then is dropped.
- R12: With LEGACY=1 both host pins are active high (low after reset). The start of a session raises host_sess and host_ack SESS_DLY cycles after the sr_load of byte 0.
- R13: With LEGACY=1 a collision drives both pins low and moves straight into reading, and host_sess rises SESS_DLY cycles later with no further sr_done. The end of a read emits the packet in the same cycle, without waiting for a read-done sr_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered this cycle |
| req_data | input | MAXLEN*8 | Request bytes, byte i at bits 8i+7:8i, byte 0 is the type |
| req_len | input | clog2(MAXLEN+1) | Request length in bytes |
| req_reply | input | 1 | Request expects a reply |
| req_ready | output | 1 | Queue has room |
| req_err | output | 1 | Pulse: previous cycle's request was malformed |
| sr_done | input | 1 | Shift unit finished a byte |
| sr_rdata | input | 8 | Byte received by the shift unit |
| sr_wdata | output | 8 | Byte to send |
| sr_load | output | 1 | Pulse: load sr_wdata into the shift unit |
| sr_rd | output | 1 | Pulse: shift unit data consumed or discarded |
| sr_dir_out | output | 1 | 1 = shift unit sends, 0 = receives |
| peer_want_n | input | 1 | Peer transfer request, active low |
| host_ack | output | 1 | Byte acknowledge pin |
| host_sess | output | 1 | Session pin |
| pkt_valid | output | 1 | Pulse: completion record valid |
| pkt_reply | output | 1 | Record closes a request (1) or is unsolicited (0) |
| pkt_len | output | clog2(RXDEPTH+1) | Delivered length |
| pkt_data | output | RXDEPTH*8 | Delivered bytes, byte i at bits 8i+7:8i |

## Verification
A table of reply cases drives request-then-reply exchanges. The cases differ in request type, reply length and byte-1 flag, which separates the unchanged, emptied and two-byte-trimmed outcomes of the reply rule. Directed runs then cover a collision followed by an unsolicited packet and a retry, and a peer that overruns the buffer and keeps asking. They also cover a queue filled behind a busy peer, which shows order and the dropped extra request, and malformed requests. A second instance in the legacy setting is timed from byte load to pin rise, and through a collision that must turn into reading with no further strobe.

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine #(
  parameter int MAXLEN = 16,
  parameter int QDEPTH = 4,
  parameter int RXDEPTH = 16,
  parameter bit LEGACY = 1'b0,
  parameter int SESS_DLY = 56250,
  parameter int ACK_ON_DLY = 37500,
  parameter int ACK_OFF_DLY = 50000,
  parameter logic [7:0] BUS_TYPE = 8'h00,
  parameter logic [7:0] CMD_TYPE = 8'h01
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [MAXLEN*8-1:0]            req_data,
  input  logic [$clog2(MAXLEN+1)-1:0]    req_len,
  input  logic                           req_reply,
  output logic                           req_ready,
  output logic                           req_err,
  input  logic                           sr_done,
  input  logic [7:0]                     sr_rdata,
  output logic [7:0]                     sr_wdata,
  output logic                           sr_load,
  output logic                           sr_rd,
  output logic                           sr_dir_out,
  input  logic                           peer_want_n,
  output logic                           host_ack,
  output logic                           host_sess,
  output logic                           pkt_valid,
  output logic                           pkt_reply,
  output logic [$clog2(RXDEPTH+1)-1:0]   pkt_len,
  output logic [RXDEPTH*8-1:0]           pkt_data
);
  localparam int LW  = $clog2(MAXLEN+1);
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCW = $clog2(QDEPTH+1);
  localparam int RCW = $clog2(RXDEPTH+1);
  localparam int CW  = 16;

  typedef enum logic [2:0] {S_IDLE, S_FIRST, S_SEND, S_READ, S_RDONE, S_AWAIT} st_t;

  st_t state;
  logic [MAXLEN*8-1:0] q_data [QDEPTH];
  logic [LW-1:0]       q_len  [QDEPTH];
  logic                q_rep  [QDEPTH];
  logic [QAW-1:0]      q_wp, q_rp;
  logic [QCW-1:0]      q_cnt;
  logic [LW-1:0]       idx;
  logic [RXDEPTH*8-1:0] rbuf, rx_view;
  logic [RCW-1:0]      rcnt, fin_len;
  logic                rd_reply, sess_q, ack_q, ev_q;
  logic                pend_q, p_sess, p_ack;
  logic [CW-1:0]       dly;

  function automatic logic [QAW-1:0] nxt(input logic [QAW-1:0] p);
    return (p == QAW'(QDEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  wire [MAXLEN*8-1:0] head_data = q_data[q_rp];
  wire [LW-1:0] head_len  = q_len[q_rp];
  wire          head_rep  = q_rep[q_rp];
  wire [7:0]    head_type = head_data[7:0];
  wire [7:0]    head_byte = head_data[{idx, 3'b000} +: 8];

  wire req_ok = (req_len >= LW'(2)) && (req_len <= LW'(MAXLEN)) && (req_data[7:0] <= CMD_TYPE);
  assign req_ready = (q_cnt != QCW'(QDEPTH));
  wire push = req_valid && req_ready && req_ok;

  wire want    = !peer_want_n;
  wire ev      = sr_done | ev_q;
  wire go      = !pend_q;
  wire take    = ev && go;
  wire last_tx = (idx >= head_len);
  wire rx_full = (rcnt == RCW'(RXDEPTH));
  wire rd_end  = (state == S_READ) && take && (!want || rx_full);
  wire finish  = ((state == S_RDONE) && take) || (LEGACY && rd_end);
  wire pop     = (take && (state == S_SEND) && last_tx && !head_rep) || (finish && rd_reply);

  always_comb begin
    rx_view = rbuf;
    if ((state == S_READ) && take && !rx_full)
      rx_view[{rcnt, 3'b000} +: 8] = sr_rdata;
  end

  assign fin_len = ((state == S_READ) && !rx_full) ? rcnt + 1'b1 : rcnt;
  wire is_bus = rd_reply && (head_type == BUS_TYPE);
  wire trim   = is_bus && (fin_len > RCW'(2)) && !rx_view[9];
  wire empty  = is_bus && !trim;

  assign host_sess = LEGACY ? sess_q : !sess_q;
  assign host_ack  = LEGACY ? ack_q  : !ack_q;

  always_ff @(posedge clk) begin
    if (push) begin
      q_data[q_wp] <= req_data;
      q_len[q_wp]  <= req_len;
      q_rep[q_wp]  <= req_reply;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp <= '0;
      q_rp <= '0;
      q_cnt <= '0;
    end else begin
      if (push) q_wp <= nxt(q_wp);
      if (pop)  q_rp <= nxt(q_rp);
      case ({push, pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0;
      rbuf <= '0;
      rcnt <= '0;
      rd_reply <= 1'b0;
      sess_q <= 1'b0;
      ack_q <= 1'b0;
      ev_q <= 1'b0;
      pend_q <= 1'b0;
      p_sess <= 1'b0;
      p_ack <= 1'b0;
      dly <= '0;
      sr_wdata <= '0;
      sr_load <= 1'b0;
      sr_rd <= 1'b0;
      sr_dir_out <= 1'b0;
      req_err <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_reply <= 1'b0;
      pkt_len <= '0;
      pkt_data <= '0;
    end else begin
      sr_load <= 1'b0;
      sr_rd <= 1'b0;
      pkt_valid <= 1'b0;
      req_err <= req_valid && !req_ok;
      ev_q <= ev && !take;

      if (pend_q) begin
        if (dly == CW'(1)) begin
          sess_q <= p_sess;
          ack_q <= p_ack;
          pend_q <= 1'b0;
        end else begin
          dly <= dly - 1'b1;
        end
      end

      case (state)
        S_IDLE, S_AWAIT: begin
          if (take) begin
            sr_rd <= 1'b1;
            rd_reply <= (state == S_AWAIT);
            rcnt <= '0;
            state <= S_READ;
            if (LEGACY) begin
              pend_q <= 1'b1; p_sess <= 1'b1; p_ack <= ack_q; dly <= CW'(SESS_DLY);
            end else begin
              sess_q <= 1'b1;
            end
          end else if (state == S_IDLE && go && q_cnt != '0 && !want) begin
            sr_dir_out <= 1'b1;
            sr_wdata <= head_data[7:0];
            sr_load <= 1'b1;
            idx <= LW'(1);
            state <= S_FIRST;
            if (LEGACY) begin
              pend_q <= 1'b1; p_sess <= 1'b1; p_ack <= 1'b1; dly <= CW'(SESS_DLY);
            end else begin
              sess_q <= 1'b1;
            end
          end
        end
        S_FIRST, S_SEND: begin
          if (take) begin
            if ((state == S_FIRST && want) || (state == S_SEND && last_tx)) begin
              sr_dir_out <= 1'b0;
              sr_rd <= 1'b1;
              if (state == S_FIRST) begin
                sess_q <= 1'b0;
                ack_q <= 1'b0;
                if (LEGACY) begin
                  state <= S_READ;
                  rd_reply <= 1'b0;
                  rcnt <= '0;
                  pend_q <= 1'b1; p_sess <= 1'b1; p_ack <= 1'b0; dly <= CW'(SESS_DLY);
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                if (LEGACY) begin
                  pend_q <= 1'b1; p_sess <= 1'b0; p_ack <= 1'b0; dly <= CW'(ACK_ON_DLY);
                end else begin
                  sess_q <= 1'b0;
                  ack_q <= 1'b0;
                end
                if (head_rep) begin
                  state <= S_AWAIT;
                end else begin
                  pkt_valid <= 1'b1;
                  pkt_reply <= 1'b1;
                  pkt_len <= '0;
                  state <= S_IDLE;
                end
              end
            end else begin
              sr_wdata <= head_byte;
              sr_load <= 1'b1;
              idx <= idx + 1'b1;
              ack_q <= !ack_q;
              state <= S_SEND;
              if (LEGACY) begin
                pend_q <= 1'b1; p_sess <= sess_q; p_ack <= ack_q; dly <= CW'(ACK_OFF_DLY);
              end
            end
          end
        end
        S_READ: begin
          if (take) begin
            sr_rd <= 1'b1;
            rbuf <= rx_view;
            if (!rx_full) rcnt <= rcnt + 1'b1;
            if (!want || rx_full) begin
              if (LEGACY) begin
                pend_q <= 1'b1; p_sess <= 1'b0; p_ack <= 1'b0; dly <= CW'(ACK_ON_DLY);
              end else begin
                sess_q <= 1'b0;
                ack_q <= 1'b0;
                state <= S_RDONE;
              end
            end else begin
              ack_q <= !ack_q;
              if (LEGACY) begin
                pend_q <= 1'b1; p_sess <= sess_q; p_ack <= ack_q; dly <= CW'(ACK_ON_DLY);
              end
            end
          end
        end
        S_RDONE: begin
          if (take) sr_rd <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase

      if (finish) begin
        pkt_valid <= 1'b1;
        pkt_reply <= rd_reply;
        pkt_len <= empty ? '0 : (trim ? fin_len - RCW'(2) : fin_len);
        pkt_data <= trim ? (rx_view >> 16) : rx_view;
        rcnt <= '0;
        rd_reply <= 1'b0;
        if (want) begin
          state <= S_READ;
          if (LEGACY) begin
            sess_q <= 1'b0;
            ack_q <= 1'b0;
            pend_q <= 1'b1; p_sess <= 1'b1; p_ack <= 1'b0; dly <= CW'(SESS_DLY);
          end else begin
            sess_q <= 1'b1;
          end
        end else begin
          state <= S_IDLE;
        end
      end
    end
  end

  p_load_dir_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> sr_dir_out);
  p_read_dir_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rd |-> !sr_dir_out);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !pend_q) |-> (!sess_q && !ack_q));
  p_tx_ack_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY && state == S_SEND && $past(state) == S_SEND && $past(take)) |-> (ack_q != $past(ack_q)));
  p_read_in_session_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && !pend_q) |-> sess_q);
  p_rx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= RCW'(RXDEPTH));
  p_queue_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QCW'(QDEPTH));
endmodule

// File: tb/hsk_xfer_engine_test.sv
`timescale 1ns/1ps
module hsk_xfer_engine_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [127:0] req_data = '0;
  logic [4:0] req_len = '0;
  logic req_reply = 1'b0;
  logic req_ready, req_err;
  logic sr_done = 1'b0;
  logic [7:0] sr_rdata = '0;
  logic [7:0] sr_wdata;
  logic sr_load, sr_rd, sr_dir_out;
  logic peer_want_n = 1'b1;
  logic host_ack, host_sess, pkt_valid, pkt_reply;
  logic [4:0] pkt_len;
  logic [127:0] pkt_data;

  hsk_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
    .req_len(req_len), .req_reply(req_reply), .req_ready(req_ready), .req_err(req_err),
    .sr_done(sr_done), .sr_rdata(sr_rdata), .sr_wdata(sr_wdata), .sr_load(sr_load),
    .sr_rd(sr_rd), .sr_dir_out(sr_dir_out), .peer_want_n(peer_want_n),
    .host_ack(host_ack), .host_sess(host_sess), .pkt_valid(pkt_valid),
    .pkt_reply(pkt_reply), .pkt_len(pkt_len), .pkt_data(pkt_data));

  logic lg_valid = 1'b0;
  logic [127:0] lg_data = '0;
  logic lg_done = 1'b0;
  logic [7:0] lg_rdata = '0;
  logic lg_want_n = 1'b1;
  logic lg_ready, lg_err, lg_load, lg_rd, lg_dir, lg_ack, lg_sess, lg_pv, lg_prep;
  logic [7:0] lg_wdata;
  logic [4:0] lg_plen;
  logic [127:0] lg_pdata;

  hsk_xfer_engine #(.LEGACY(1'b1), .SESS_DLY(5), .ACK_ON_DLY(3), .ACK_OFF_DLY(4)) uut_lg (
    .clk(clk), .rst_n(rst_n), .req_valid(lg_valid), .req_data(lg_data),
    .req_len(5'd2), .req_reply(1'b0), .req_ready(lg_ready), .req_err(lg_err),
    .sr_done(lg_done), .sr_rdata(lg_rdata), .sr_wdata(lg_wdata), .sr_load(lg_load),
    .sr_rd(lg_rd), .sr_dir_out(lg_dir), .peer_want_n(lg_want_n),
    .host_ack(lg_ack), .host_sess(lg_sess), .pkt_valid(lg_pv),
    .pkt_reply(lg_prep), .pkt_len(lg_plen), .pkt_data(lg_pdata));

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_byte(input logic [7:0] t, input logic [7:0] b1, input int i);
    return (i == 0) ? t : b1 + 8'(i);
  endfunction

  function automatic logic [7:0] rx_byte(input logic [7:0] b1, input int i);
    return (i == 1) ? b1 : 8'hA0 + 8'(i);
  endfunction

  task automatic push(input logic [7:0] t, input logic [7:0] b1, input int len, input bit rep);
    req_valid = 1'b1;
    for (int i = 0; i < 16; i++) req_data[i*8 +: 8] = tx_byte(t, b1, i);
    req_len = 5'(len);
    req_reply = rep;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic strobe();
    sr_done = 1'b1;
    @(negedge clk);
    sr_done = 1'b0;
  endtask

  task automatic wait_load();
    for (int k = 0; k < 60; k++) begin
      if (sr_load) break;
      @(negedge clk);
    end
  endtask

  task automatic host_tx(input int n, input logic [7:0] t, input logic [7:0] b1);
    for (int i = 0; i < n; i++) begin
      logic a;
      wait_load();
      chk("R5", "sent byte", sr_wdata, tx_byte(t, b1, i));
      if (i == 0) begin
        chk("R3", "dir out at start", sr_dir_out, 1);
        chk("R3", "session low at start", host_sess, 0);
      end
      a = host_ack;
      strobe();
      if (i < n - 1) chk("R5", "ack inverted", host_ack, !a);
    end
    chk("R6", "dir in after last", sr_dir_out, 0);
    chk("R6", "session high after last", host_sess, 1);
    chk("R6", "ack high after last", host_ack, 1);
  endtask

  task automatic peer_rx(input int n, input logic [7:0] b1);
    peer_want_n = 1'b0;
    strobe();
    chk("R7", "session low after attention", host_sess, 0);
    for (int i = 0; i < n; i++) begin
      logic a;
      sr_rdata = rx_byte(b1, i);
      if (i == n - 1) peer_want_n = 1'b1;
      a = host_ack;
      strobe();
      if (i < n - 1) chk("R7", "ack inverted on read", host_ack, !a);
      else chk("R7", "session high at read end", host_sess, 1);
    end
    strobe();
    chk("R7", "packet emitted", pkt_valid, 1);
  endtask

  localparam logic [39:0] VEC [6] = '{
    {8'h01, 8'd4, 8'h02, 8'd4, 8'd0},
    {8'h00, 8'd2, 8'h00, 8'd0, 8'd0},
    {8'h00, 8'd5, 8'h00, 8'd3, 8'd2},
    {8'h00, 8'd5, 8'h02, 8'd0, 8'd0},
    {8'h00, 8'd3, 8'h40, 8'd1, 8'd2},
    {8'h01, 8'd1, 8'h00, 8'd1, 8'd0}
  };

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "session pin", host_sess, 1);
    chk("R1", "ack pin", host_ack, 1);
    chk("R1", "pkt_valid", pkt_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "dir", sr_dir_out, 0);
    chk("R12", "legacy session pin", lg_sess, 0);
    chk("R12", "legacy ack pin", lg_ack, 0);

    push(8'h01, 8'h00, 1, 1'b0);
    chk("R2", "short request err", req_err, 1);
    push(8'h02, 8'h00, 3, 1'b0);
    chk("R2", "bad type err", req_err, 1);
    cnt = 0;
    repeat (10) begin @(negedge clk); if (sr_load) cnt++; end
    chk("R2", "nothing sent", cnt, 0);
    chk("R2", "session stays high", host_sess, 1);

    for (int v = 0; v < 6; v++) begin
      logic [39:0] e;
      e = VEC[v];
      push(e[39:32], 8'h30, 3, 1'b1);
      host_tx(3, e[39:32], 8'h30);
      chk("R6", "no record before reply", pkt_valid, 0);
      peer_rx(int'(e[31:24]), e[23:16]);
      chk("R9", "reply flag", pkt_reply, 1);
      chk("R9", "reply length", pkt_len, int'(e[15:8]));
      if (e[15:8] != 0)
        chk("R9", "reply first byte", pkt_data[7:0], rx_byte(e[23:16], int'(e[7:0])));
      @(negedge clk);
    end

    push(8'h01, 8'h50, 2, 1'b0);
    wait_load();
    peer_want_n = 1'b0;
    strobe();
    chk("R4", "dir in on collision", sr_dir_out, 0);
    chk("R4", "dummy read", sr_rd, 1);
    chk("R4", "session high", host_sess, 1);
    chk("R4", "ack high", host_ack, 1);
    peer_rx(2, 8'h11);
    chk("R7", "unsolicited flag", pkt_reply, 0);
    chk("R7", "unsolicited length", pkt_len, 2);
    chk("R7", "unsolicited byte0", pkt_data[7:0], 8'hA0);
    host_tx(2, 8'h01, 8'h50);
    chk("R6", "no-reply completion", pkt_valid, 1);
    chk("R6", "completion flag", pkt_reply, 1);
    chk("R6", "completion length", pkt_len, 0);
    @(negedge clk);

    peer_want_n = 1'b0;
    strobe();
    for (int i = 0; i < 16; i++) begin
      sr_rdata = 8'h40 + 8'(i);
      strobe();
    end
    chk("R8", "still reading at full", host_sess, 0);
    sr_rdata = 8'hEE;
    strobe();
    chk("R8", "read ends when full", host_sess, 1);
    strobe();
    chk("R8", "full length", pkt_len, 16);
    chk("R8", "first byte", pkt_data[7:0], 8'h40);
    chk("R8", "last byte", pkt_data[127:120], 8'h4F);
    chk("R10", "restart reading at once", host_sess, 0);
    sr_rdata = 8'h77;
    peer_want_n = 1'b1;
    strobe();
    strobe();
    chk("R10", "restarted length", pkt_len, 1);
    chk("R10", "restarted byte", pkt_data[7:0], 8'h77);
    @(negedge clk);

    peer_want_n = 1'b0;
    for (int k = 0; k < 4; k++) push(8'h01, 8'h60 + 8'(k * 16), 2, 1'b0);
    chk("R11", "ready low when full", req_ready, 0);
    push(8'h01, 8'hF0, 2, 1'b0);
    chk("R11", "extra not refused as malformed", req_err, 0);
    chk("R11", "ready still low", req_ready, 0);
    peer_want_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      host_tx(2, 8'h01, 8'h60 + 8'(k * 16));
      chk("R10", "next queued done", pkt_valid, 1);
    end
    cnt = 0;
    repeat (20) begin @(negedge clk); if (sr_load) cnt++; end
    chk("R11", "fifth request dropped", cnt, 0);

    lg_valid = 1'b1;
    lg_data = '0;
    lg_data[7:0] = 8'h01;
    @(negedge clk);
    lg_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (lg_load) break;
      @(negedge clk);
    end
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (lg_sess) break;
      @(negedge clk);
      cnt++;
    end
    chk("R12", "session delay", cnt, 5);
    chk("R12", "ack active high", lg_ack, 1);
    lg_want_n = 1'b0;
    lg_done = 1'b1;
    @(negedge clk);
    lg_done = 1'b0;
    chk("R13", "collision pins low", lg_sess, 0);
    chk("R13", "collision dir in", lg_dir, 0);
    repeat (5) @(negedge clk);
    chk("R13", "session rises without strobe", lg_sess, 1);
    lg_rdata = 8'h5A;
    lg_want_n = 1'b1;
    lg_done = 1'b1;
    @(negedge clk);
    lg_done = 1'b0;
    chk("R13", "packet at read end", lg_pv, 1);
    chk("R13", "packet length", lg_plen, 1);
    chk("R13", "packet byte", lg_pdata[7:0], 8'h5A);
    chk("R13", "unsolicited", lg_prep, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule